// File: doc/BRIEF.md
# Deferred Interrupt and Alert Logic

This block gathers power-management events from the ports of a powered-Ethernet supply controller. It latches each event into a sticky event register and combines that register with a host-programmed 8-bit enable mask. From the result it drives an active-low interrupt line meant for an open-drain pad. The interrupt line never changes while a transaction is in progress on the two-wire management bus. A newly raised interrupt, or a clear made by the host, reaches the pin only in the idle gap after a STOP and before the next START.

A host that does not wire the interrupt pin can poll the SMBus alert response address instead. The block tells the bus slave to acknowledge that address, and supplies this device's own address byte, exactly when the interrupt line is being driven low.

The host reaches the registers through a simple read/write port with a 2-bit address:

- address 0: event register, cleared when read
- address 1: mask, read/write
- address 2: write-one-to-clear port for the event register
- address 3: event register, read without side effect

Top module: `evt_irq_defer`

## Requirements
- R1: After a synchronous active-low reset, `irq_n` is 1, `ara_ack` is 0, the event register reads 0x00 and the mask reads 0x00.
- R2: A one-cycle pulse on bit i of `evt_strobe` sets event bit i, and the bit stays set until it is cleared. The bit meanings are: 7 supply fault, 6 start-up timeout, 5 run-time overcurrent cutoff, 4 classification done, 3 detection done, 2 disconnect, 1 power good, 0 power-enable change.
- R3: A read at address 0 returns the event register in the same cycle through `reg_rdata`. The read then clears every event bit. A read at address 3 returns the same value and clears nothing.
- R4: A write at address 2 clears exactly the event bits whose write-data bits are 1. All other event bits keep their values.
- R5: When a strobe and a clear (read-clear or write-one-to-clear) hit the same bit in the same cycle, the bit is set afterwards.
- R6: The mask at address 1 reads back the value last written. The interrupt condition is the OR over all bits of (events AND mask). An event whose mask bit is 0 leaves `irq_n` at 1.
- R7: `bus_start` marks the bus busy and `bus_stop` marks it free. While the bus is busy, and in the cycle of a START, `irq_n` holds its value. When the bus is free, `irq_n` equals the inverse of the interrupt condition one cycle later. After a STOP, the pending value therefore appears two cycles after the STOP cycle.
- R8: `addr_valid` can carry the alert response address 0001100b while `irq_n` is 0. In that case `ara_ack` is 1 in the next cycle and `ara_byte` equals the device address shifted left by one, which is 0x40 by default. For any other address, or while `irq_n` is 1, `ara_ack` stays 0.
- R9: A mask of 0xF4 enables bits 7, 6, 5, 4 and 2 only. With that mask, a detection-done event (bit 3) leaves `irq_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_strobe | input | 8 | One-cycle event pulses, one per event bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 read-clear, 1 mask, 2 W1C, 3 peek) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| bus_start | input | 1 | START condition seen on the management bus |
| bus_stop | input | 1 | STOP condition seen on the management bus |
| addr_valid | input | 1 | Slave has received an address byte |
| addr_rx | input | 7 | Received 7-bit address |
| ara_ack | output | 1 | Acknowledge the alert response address |
| ara_byte | output | 8 | Byte returned on an alert response |
| irq_n | output | 1 | Active-low interrupt, for an open-drain pad |

## Verification
The hardest condition to reach is a change to the interrupt condition while the pin is frozen. This has to be tested in both directions: an event arriving mid-transaction, and a read-clear made from inside a transaction. In each case the pin must move on the second cycle after STOP and not earlier. The stimulus opens a transaction with a START, changes the events inside it, and checks the pin in the STOP cycle, one cycle after it and two cycles after it. The alert response is tested inside such a frozen window. The stimulus then clears the source event in the idle gap and repeats the poll, which shows that the acknowledge follows the pin rather than the raw events.

// File: rtl/evt_irq_pkg.sv
// Package: shared constants for the deferred interrupt block.
// Assumes an 8-bit event vector; register addresses are 2 bits wide.
package evt_irq_pkg;
    localparam int EVT_W  = 8;
    localparam int BUSA_W = 7;
    localparam int REGA_W = 2;

    localparam logic [BUSA_W-1:0] ALERT_RESP_ADDR = 7'b0001100;

    typedef enum logic [REGA_W-1:0] {
        RA_EVT_RC   = 2'd0,
        RA_MASK     = 2'd1,
        RA_EVT_W1C  = 2'd2,
        RA_EVT_PEEK = 2'd3
    } reg_addr_e;

    // event bit positions
    localparam int EB_PWR_EN_CHG = 0;
    localparam int EB_PWR_GOOD   = 1;
    localparam int EB_DISCONNECT = 2;
    localparam int EB_DET_DONE   = 3;
    localparam int EB_CLS_DONE   = 4;
    localparam int EB_CUTOFF     = 5;
    localparam int EB_START_TO   = 6;
    localparam int EB_SUPPLY_FLT = 7;
endpackage

// File: rtl/evt_sticky_reg.sv
// Module: sticky event register.
// Each bit is set by a strobe and cleared by a clear vector.
// If a strobe and a clear hit the same bit in one cycle, the strobe wins.
// Assumes strobes are single-cycle and synchronous to clk.
module evt_sticky_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] strobe,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] evt_q
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            // Per-bit latch: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    evt_q[gi] <= 1'b0;
                else if (strobe[gi])
                    evt_q[gi] <= 1'b1;
                else if (clr_vec[gi])
                    evt_q[gi] <= 1'b0;
            end
        end
    endgenerate

    // R2: a bit that is set and not cleared stays set.
    assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_q & $past(evt_q & ~clr_vec)) == $past(evt_q & ~clr_vec)));

    // R5: a strobed bit is set afterwards, even when a clear hit it too.
    assert_strobe_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobe) |=> ((evt_q & $past(strobe)) == $past(strobe)));
endmodule

// File: rtl/evt_bus_gap.sv
// Module: bus-busy tracking and deferred update of the interrupt state.
// Busy is set by START and cleared by STOP; START wins if both arrive together.
// The interrupt state follows the pending condition only while the bus is idle.
module evt_bus_gap (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_start,
    input  logic bus_stop,
    input  logic pending,
    output logic busy_q,
    output logic irq_q
);
    // Track whether a transaction is open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (bus_start)
            busy_q <= 1'b1;
        else if (bus_stop)
            busy_q <= 1'b0;
    end

    // Sample the pending condition only in the inter-transaction gap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (!busy_q && !bus_start)
            irq_q <= pending;
    end

    // R7: the interrupt state is frozen while a transaction is open.
    assert_irq_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(irq_q));

    // R7: after a START the bus reads busy in the next cycle.
    assert_busy_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> busy_q);
endmodule

// File: rtl/evt_alert_resp.sv
// Module: alert response address responder.
// Registers an acknowledge one cycle after a received address equals the
// alert response address while the interrupt is asserted. It also returns
// this device's own address byte.
module evt_alert_resp #(
    parameter int                ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h20,
    parameter logic [ADDR_W-1:0] RESP_ADR = 7'b0001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_rx,
    input  logic              irq_q,
    output logic              ara_ack,
    output logic [ADDR_W:0]   ara_byte
);
    logic hit;
    assign hit = addr_valid && (addr_rx == RESP_ADR) && irq_q;

    // Register the acknowledge and the returned address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ara_ack  <= 1'b0;
            ara_byte <= '0;
        end else begin
            ara_ack  <= hit;
            ara_byte <= hit ? {DEV_ADDR, 1'b0} : '0;
        end
    end

    // R8: the acknowledge only follows a cycle in which the interrupt was asserted.
    assert_ack_needs_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ara_ack |-> $past(irq_q));

    // R8: a non-matching or absent address never produces an acknowledge.
    assert_ack_needs_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && addr_rx == RESP_ADR) |=> !ara_ack);
endmodule

// File: rtl/evt_irq_defer.sv
// Module: top of the deferred interrupt and alert logic.
// Decodes the register port:
//   address 0 reads the events and clears them,
//   address 1 holds the mask,
//   address 2 clears events written as one,
//   address 3 reads the events without side effect.
// Combines events with the mask and drives an active-low interrupt
// that only moves between bus transactions.
module evt_irq_defer
    import evt_irq_pkg::*;
#(
    parameter logic [BUSA_W-1:0] DEV_ADDR = 7'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_strobe,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REGA_W-1:0] reg_addr,
    input  logic [EVT_W-1:0]  reg_wdata,
    output logic [EVT_W-1:0]  reg_rdata,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              addr_valid,
    input  logic [BUSA_W-1:0] addr_rx,
    output logic              ara_ack,
    output logic [EVT_W-1:0]  ara_byte,
    output logic              irq_n
);
    logic [EVT_W-1:0] evt_q;
    logic [EVT_W-1:0] mask_q;
    logic [EVT_W-1:0] clr_vec;
    logic             pending;
    logic             busy_q;
    logic             irq_q;

    // Build the clear vector from read-clear and write-one-to-clear accesses.
    always_comb begin
        clr_vec = '0;
        if (reg_rd && reg_addr == RA_EVT_RC)
            clr_vec = '1;
        else if (reg_wr && reg_addr == RA_EVT_W1C)
            clr_vec = reg_wdata;
    end

    // Hold the host-written mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_wr && reg_addr == RA_MASK)
            mask_q <= reg_wdata;
    end

    // Return register contents for the addressed location.
    always_comb begin
        unique case (reg_addr)
            RA_EVT_RC, RA_EVT_PEEK: reg_rdata = evt_q;
            RA_MASK:                reg_rdata = mask_q;
            default:                reg_rdata = '0;
        endcase
    end

    assign pending = |(evt_q & mask_q);
    assign irq_n   = ~irq_q;

    evt_sticky_reg #(.W(EVT_W)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (evt_strobe),
        .clr_vec (clr_vec),
        .evt_q   (evt_q)
    );

    evt_bus_gap u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .pending   (pending),
        .busy_q    (busy_q),
        .irq_q     (irq_q)
    );

    evt_alert_resp #(
        .ADDR_W   (BUSA_W),
        .DEV_ADDR (DEV_ADDR),
        .RESP_ADR (ALERT_RESP_ADDR)
    ) u_ara (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_valid (addr_valid),
        .addr_rx    (addr_rx),
        .irq_q      (irq_q),
        .ara_ack    (ara_ack),
        .ara_byte   (ara_byte)
    );

    // R7: in the idle gap the interrupt follows the pending condition after one cycle.
    assert_idle_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !bus_start) |=> (irq_q == $past(pending)));

    // R6: the interrupt is never raised in the gap without a masked-in event.
    assert_irq_needs_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !bus_start && !(|(evt_q & mask_q))) |=> !irq_q);

    // R4: a write-one-to-clear leaves unselected bits untouched.
    assert_w1c_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_EVT_W1C && !reg_rd)
        |=> ((evt_q & ~$past(reg_wdata)) == ($past(evt_q) & ~$past(reg_wdata))
             | ($past(evt_strobe) & ~$past(reg_wdata))));
endmodule

// File: tb/sim_evt_irq_defer.sv
// Bench: scoreboard. Driver steps push expected values tagged with the cycle
// they are due in; a monitor at the falling edge pops and compares them.
module sim_evt_irq_defer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_strobe = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       addr_valid = 1'b0;
    logic [6:0] addr_rx = '0;
    logic       ara_ack;
    logic [7:0] ara_byte;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        int         sel;   // 0 irq_n, 1 reg_rdata, 2 ara_ack, 3 ara_byte
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    evt_irq_defer u0 (
        .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_valid(addr_valid), .addr_rx(addr_rx),
        .ara_ack(ara_ack), .ara_byte(ara_byte), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every item due now and compare against the outputs.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.sel)
                0:       act = {7'd0, irq_n};
                1:       act = reg_rdata;
                2:       act = {7'd0, ara_ack};
                default: act = ara_byte;
            endcase
            checks++;
            if (it.due < cyc || act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d cyc=%0d actual=%h expected=%h",
                         it.req, it.sel, cyc, act, it.exp);
            end
        end
    end

    task automatic expect_now(input int sel, input logic [7:0] exp, input string req);
        item_t it;
        it.due = cyc; it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        evt_strobe = '0; reg_wr = 0; reg_rd = 0; bus_start = 0;
        bus_stop = 0; addr_valid = 0;
    endtask

    task automatic rd(input logic [1:0] a);
        reg_rd = 1; reg_addr = a;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1: reset state
        expect_now(0, 8'h01, "R1 irq_n"); expect_now(2, 8'h00, "R1 ack");
        rd(2'd3); expect_now(1, 8'h00, "R1 events");
        step(); rd(2'd1); expect_now(1, 8'h00, "R1 mask");

        // R6: mask write and readback
        step(); wr(2'd1, 8'hF4);
        step(); rd(2'd1); expect_now(1, 8'hF4, "R6 mask readback");

        // R6: unmasked power-good event is latched but raises nothing
        step(); evt_strobe = 8'h02;
        step(); step();
        step(); rd(2'd3); expect_now(1, 8'h02, "R2 sticky power good");
        expect_now(0, 8'h01, "R6 unmasked no irq");

        // R2: classification done raises irq two cycles later
        step(); evt_strobe = 8'h10;
        step(); expect_now(0, 8'h01, "R2 irq not yet");
        step(); expect_now(0, 8'h00, "R2 irq asserted");

        // R3: read-clear
        step(); rd(2'd0); expect_now(1, 8'h12, "R3 read-clear value");
        step(); rd(2'd3); expect_now(1, 8'h00, "R3 cleared");
        expect_now(0, 8'h00, "R7 irq one cycle lag");
        step(); expect_now(0, 8'h01, "R3 irq released");

        // R7: event inside a transaction is deferred
        step(); bus_start = 1;
        step(); evt_strobe = 8'h40;
        step(); step();
        step(); expect_now(0, 8'h01, "R7 frozen high");
        step(); bus_stop = 1; expect_now(0, 8'h01, "R7 frozen at stop");
        step(); expect_now(0, 8'h01, "R7 stop+1");
        step(); expect_now(0, 8'h00, "R7 stop+2 asserted");

        // R7: clear inside a transaction is deferred
        step(); bus_start = 1;
        step(); rd(2'd0); expect_now(1, 8'h40, "R3 read inside txn");
        step(); expect_now(0, 8'h00, "R7 clear frozen");
        step(); bus_stop = 1; expect_now(0, 8'h00, "R7 clear frozen at stop");
        step(); expect_now(0, 8'h00, "R7 clear stop+1");
        step(); expect_now(0, 8'h01, "R7 clear stop+2 released");

        // R8: alert response while irq asserted
        step(); evt_strobe = 8'h80;
        step(); step(); expect_now(0, 8'h00, "R6 supply fault irq");
        step(); bus_start = 1;
        step(); addr_valid = 1; addr_rx = 7'h0C;
        step(); expect_now(2, 8'h01, "R8 ack"); expect_now(3, 8'h40, "R8 byte");
        addr_valid = 1; addr_rx = 7'h21;
        step(); expect_now(2, 8'h00, "R8 other addr no ack"); bus_stop = 1;
        step(); wr(2'd2, 8'h80);
        step(); step(); expect_now(0, 8'h01, "R4 w1c released irq");
        step(); bus_start = 1;
        step(); addr_valid = 1; addr_rx = 7'h0C;
        step(); expect_now(2, 8'h00, "R8 no ack when idle irq"); bus_stop = 1;

        // R4: partial write-one-to-clear
        step(); evt_strobe = 8'h25;
        step(); wr(2'd2, 8'h20);
        step(); rd(2'd3); expect_now(1, 8'h05, "R4 partial clear");

        // R5: strobe beats clear
        step(); evt_strobe = 8'h04; wr(2'd2, 8'h04);
        step(); rd(2'd3); expect_now(1, 8'h05, "R5 strobe beats w1c");
        step(); rd(2'd0); evt_strobe = 8'h08; expect_now(1, 8'h05, "R5 read value");
        step(); rd(2'd3); expect_now(1, 8'h08, "R5 strobe beats read-clear");

        // R9: detection done not enabled by F4h
        step(); step(); expect_now(0, 8'h01, "R9 bit3 masked by F4");
        wr(2'd1, 8'h08);
        step(); rd(2'd1); expect_now(1, 8'h08, "R6 mask rewrite");
        step(); expect_now(0, 8'h00, "R6 bit3 enabled irq");

        step(); step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule